// File: doc/BRIEF.md
# I2C Register-Access Target

This block is an I2C target that lets an external bus controller read and write a bank of byte-wide internal registers. The bus lines are brought into the system clock domain through a two-stage synchroniser. Start and stop conditions are found as SDA transitions while SCL is high. The target answers one fixed 7-bit device address. It pulls SDA low through an open-drain enable to acknowledge bytes and to send read data.

A write transaction carries a register-pointer byte and then any number of data bytes. Each data byte is stored at the pointer, and the pointer then advances. A read transaction returns the register at the current pointer and continues with the following registers for as long as the controller acknowledges. The pointer keeps its value across stops and repeated starts. A short write that sets only the pointer, followed by a repeated-start read, therefore reads from that register. The register bank itself sits outside the block, behind a simple port: address, write data, a one-cycle write strobe, and combinational read data.

The controller is built around states `S_IDLE`, `S_ADDR`, `S_ADDR_ACK`, `S_PTR`, `S_PTR_ACK`, `S_WDATA`, `S_WDATA_ACK`, `S_RDATA`, `S_RD_ACK` and `S_IGNORE`.
- A stop moves any state to `S_IDLE`.
- A start or repeated start moves any state to `S_ADDR`.
- `S_ADDR` moves to `S_ADDR_ACK` on a matching address and otherwise to `S_IGNORE`, in both cases at the falling SCL edge after the eighth bit.
- `S_ADDR_ACK` moves to `S_PTR` for a write or `S_RDATA` for a read.
- `S_PTR` moves to `S_PTR_ACK`, and then to `S_WDATA`.
- `S_WDATA` and `S_WDATA_ACK` alternate.
- `S_RDATA` moves to `S_RD_ACK`. `S_RD_ACK` moves back to `S_RDATA` when the controller acknowledges and to `S_IGNORE` when it does not.

Top module: `i2c_reg_target`

## Requirements
- R1: A first byte of 0xB4 (address 0x5A, direction bit 0 = write) or 0xB5 (direction bit 1 = read) is acknowledged: SDA is held low during the ninth SCL pulse.
- R2: Any other address is not acknowledged. The target then drives nothing, acknowledges nothing and writes nothing until the next start condition. The register contents and the pointer are unchanged.
- R3: In a write transaction, the byte after the address is loaded as the register pointer and is acknowledged.
- R4: Each later data byte is acknowledged and written to the register at the pointer, after which the pointer increments. A burst of N bytes fills N consecutive registers.
- R5: Each stored data byte produces exactly one write strobe of one clock cycle, issued while SCL is low.
- R6: A stop or start that arrives before the eighth bit of a data byte discards that byte. Only complete bytes are written.
- R7: In a read transaction, the target sends the register at the current pointer, most significant bit first, and increments the pointer after each byte. It sends the next register after each controller acknowledge.
- R8: A controller not-acknowledge after a read byte ends the read. SDA is released, and later clock pulses read back as 1 until a new start.
- R9: The pointer keeps its value across stop and repeated-start conditions. A read started without a new pointer continues from where the last access left off.
- R10: After reset, SDA is released, the write strobe is low and the pointer is 0.
- R11: The pointer wraps from 0xFF to 0x00 in write and read bursts.
- R12: A repeated start in the middle of any byte, including the address byte, abandons that byte and restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| reg_rdata | input | 8 | Read data of the register at `reg_addr` |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low |
| reg_addr | output | REG_AW (8) | Register pointer / register-bank address |
| reg_wdata | output | 8 | Data byte to store |
| reg_we | output | 1 | One-cycle write strobe |

## Verification
The hardest situations to reach are a byte that is cut short and a pointer that runs past the end of the bank. A stop after only four data bits must leave no write behind. A repeated start partway through an address must not upset the next transaction. A burst starting at 0xFE must land in 0xFE, 0xFF and 0x00. The stimulus drives SDA and SCL bit by bit through its own open-drain bus model, so it can break a byte at any bit position. It then reads the affected registers back through the bus to show what was, and was not, stored. A reference model in the bench keeps the expected pointer and register image. It checks every write strobe against a queue of expected address/data pairs.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_PTR,
        S_PTR_ACK,
        S_WDATA,
        S_WDATA_ACK,
        S_RDATA,
        S_RD_ACK,
        S_IGNORE
    } tgt_state_e;

    // States in which the target samples a byte from the controller
    function automatic logic is_rx(tgt_state_e s);
        return (s == S_ADDR) || (s == S_PTR) || (s == S_WDATA);
    endfunction

    // States in which the target holds SDA low for an acknowledge
    function automatic logic is_ack(tgt_state_e s);
        return (s == S_ADDR_ACK) || (s == S_PTR_ACK) || (s == S_WDATA_ACK);
    endfunction

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stg;

    // Idle bus lines are high, so reset to ones
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg <= '1;
        end else begin
            stg <= {stg[STAGES-2:0], d};
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/i2c_tgt_cond.sv
module i2c_tgt_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    // SDA edges are only conditions while SCL stays high across both samples
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h5A,
    parameter int         REG_AW   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_s,
    input  logic [BYTE_W-1:0] reg_rdata,
    output logic              sda_oe,
    output logic [REG_AW-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_we
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    tgt_state_e        st;
    tgt_state_e        nxt;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [REG_AW-1:0] ptr;
    logic [BYTE_W-1:0] wdata_q;
    logic              we_q;
    logic              rw_q;
    logic              host_ack_q;
    logic              byte_end;
    logic              addr_hit;

    assign byte_end = scl_fall && (bit_cnt == LAST_BIT);
    assign addr_hit = (shreg[BYTE_W-1:1] == DEV_ADDR);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= S_IDLE;
        end else begin
            st <= nxt;
        end
    end

    // Next-state logic: bus conditions override every byte phase
    always_comb begin
        nxt = st;
        if (stop_det) begin
            nxt = S_IDLE;
        end else if (start_det) begin
            nxt = S_ADDR;
        end else begin
            unique case (st)
                S_IDLE:      nxt = S_IDLE;
                S_ADDR:      if (byte_end) nxt = addr_hit ? S_ADDR_ACK : S_IGNORE;
                S_ADDR_ACK:  if (scl_fall) nxt = rw_q ? S_RDATA : S_PTR;
                S_PTR:       if (byte_end) nxt = S_PTR_ACK;
                S_PTR_ACK:   if (scl_fall) nxt = S_WDATA;
                S_WDATA:     if (byte_end) nxt = S_WDATA_ACK;
                S_WDATA_ACK: if (scl_fall) nxt = S_WDATA;
                S_RDATA:     if (byte_end) nxt = S_RD_ACK;
                S_RD_ACK:    if (scl_fall) nxt = host_ack_q ? S_RDATA : S_IGNORE;
                S_IGNORE:    nxt = S_IGNORE;
            endcase
        end
    end

    // Datapath: bit counter, shifter, pointer and write port registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt    <= '0;
            shreg      <= '0;
            ptr        <= '0;
            wdata_q    <= '0;
            we_q       <= 1'b0;
            rw_q       <= 1'b0;
            host_ack_q <= 1'b0;
        end else begin
            we_q <= 1'b0;
            if (we_q) begin
                ptr <= ptr + 1'b1;
            end

            if (start_det || stop_det || (nxt != st)) begin
                bit_cnt <= '0;
            end else if (scl_rise && (is_rx(st) || (st == S_RDATA))) begin
                bit_cnt <= bit_cnt + 1'b1;
            end

            if ((nxt == S_RDATA) && (st != S_RDATA)) begin
                shreg <= reg_rdata;
            end else if (scl_rise && is_rx(st)) begin
                shreg <= {shreg[BYTE_W-2:0], sda_s};
            end else if (scl_fall && (st == S_RDATA) && (bit_cnt != LAST_BIT)) begin
                shreg <= {shreg[BYTE_W-2:0], 1'b0};
            end

            if ((st == S_ADDR) && (nxt == S_ADDR_ACK)) begin
                rw_q <= shreg[0];
            end
            if ((st == S_PTR) && (nxt == S_PTR_ACK)) begin
                ptr <= shreg[REG_AW-1:0];
            end
            if ((st == S_WDATA) && (nxt == S_WDATA_ACK)) begin
                we_q    <= 1'b1;
                wdata_q <= shreg;
            end
            if ((st == S_RDATA) && (nxt == S_RD_ACK)) begin
                ptr <= ptr + 1'b1;
            end
            if ((st == S_RD_ACK) && scl_rise) begin
                host_ack_q <= ~sda_s;
            end
        end
    end

    // Outputs
    always_comb begin
        sda_oe = 1'b0;
        unique case (st)
            S_ADDR_ACK, S_PTR_ACK, S_WDATA_ACK: sda_oe = 1'b1;
            S_RDATA:                            sda_oe = ~shreg[BYTE_W-1];
            default:                            sda_oe = 1'b0;
        endcase
    end

    assign reg_addr  = ptr;
    assign reg_wdata = wdata_q;
    assign reg_we    = we_q;

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h5A,
    parameter int         REG_AW      = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [BYTE_W-1:0] reg_rdata,
    output logic              sda_oe,
    output logic [REG_AW-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_we
);

    logic scl_s;
    logic sda_s;
    logic scl_rise;
    logic scl_fall;
    logic start_det;
    logic stop_det;

    i2c_tgt_sync #(
        .W      (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_i, sda_i}),
        .q     ({scl_s, sda_s})
    );

    i2c_tgt_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_tgt_fsm #(
        .DEV_ADDR (DEV_ADDR),
        .REG_AW   (REG_AW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_s     (sda_s),
        .reg_rdata (reg_rdata),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we)
    );

endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk #(
    parameter int REG_AW = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s,
    input logic              start_det,
    input logic              stop_det,
    input logic              sda_oe,
    input logic              reg_we,
    input logic [REG_AW-1:0] reg_addr
);

    // R5: the write strobe lasts one cycle
    p_we_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R5: the strobe is issued only while SCL is low
    p_we_scl_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> !scl_s);

    // R4: the pointer steps by one after each stored byte
    p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> (reg_addr == REG_AW'($past(reg_addr) + 1'b1)));

    // R8: SDA is released once a stop is seen
    p_release_on_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R12: a start never produces a write on the following cycle
    p_start_no_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !reg_we);

    // R6: a stop never produces a write on the following cycle
    p_stop_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !reg_we);

endmodule

bind i2c_reg_target i2c_tgt_chk #(.REG_AW(REG_AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr)
);

// File: tb/sim_i2c_reg_target.sv
module sim_i2c_reg_target;

    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic [7:0] reg_addr;
    logic [7:0] reg_wdata;
    logic       reg_we;
    logic [7:0] reg_rdata;
    wire        sda_line = sda_m & ~sda_oe;

    logic [7:0]  mem     [256];
    logic [7:0]  exp_mem [256];
    logic [15:0] wq [$];
    int          model_ptr = 0;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    assign reg_rdata = mem[reg_addr];

    i2c_reg_target u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .reg_rdata (reg_rdata),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we)
    );

    function automatic logic [7:0] init_val(int i);
        return 8'((i * 7 + 3) & 255);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Register bank model and per-clock comparison of the write port
    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
        end else if (reg_we) begin
            if (wq.size() == 0) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R2/R6 unexpected write actual=%0h:%0h expected=none",
                         reg_addr, reg_wdata);
            end else begin
                logic [15:0] e;
                e = wq.pop_front();
                chk("R4 write address", reg_addr, e[15:8]);
                chk("R4 write data", reg_wdata, e[7:0]);
            end
            mem[reg_addr] <= reg_wdata;
        end
    end

    task automatic wq_tick();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq_tick();
        scl_m = 1'b1; wq_tick();
        sda_m = 1'b0; wq_tick();
        scl_m = 1'b0; wq_tick();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq_tick();
        scl_m = 1'b1; wq_tick();
        sda_m = 1'b1; wq_tick();
        wq_tick();
    endtask

    task automatic send_bit(input bit b);
        sda_m = b;    wq_tick();
        scl_m = 1'b1; wq_tick(); wq_tick();
        scl_m = 1'b0; wq_tick();
    endtask

    task automatic recv_bit(output bit b);
        sda_m = 1'b1; wq_tick();
        scl_m = 1'b1; wq_tick();
        b = sda_line; wq_tick();
        scl_m = 1'b0; wq_tick();
    endtask

    task automatic wr_byte(input logic [7:0] d, output bit ack);
        bit b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(b);
        ack = ~b;
    endtask

    task automatic rd_byte(output logic [7:0] d, input bit ack);
        bit b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            d[i] = b;
        end
        send_bit(~ack);
    endtask

    // Model: queue an expected write and advance the pointer
    task automatic exp_wr(input logic [7:0] d);
        wq.push_back({8'(model_ptr), d});
        exp_mem[model_ptr] = d;
        model_ptr = (model_ptr + 1) & 255;
    endtask

    task automatic exp_rd(output logic [7:0] d);
        d = exp_mem[model_ptr];
        model_ptr = (model_ptr + 1) & 255;
    endtask

    task automatic set_ptr(input logic [7:0] p);
        bit ack;
        bus_start();
        wr_byte(8'hB4, ack); chk("R1 write address ack", ack, 1);
        wr_byte(p, ack);     chk("R3 pointer ack", ack, 1);
        model_ptr = p;
    endtask

    task automatic wr_burst(input logic [7:0] p, input logic [7:0] d0,
                            input logic [7:0] d1, input logic [7:0] d2);
        bit ack;
        logic [7:0] dv [3];
        dv = '{d0, d1, d2};
        set_ptr(p);
        foreach (dv[i]) begin
            exp_wr(dv[i]);
            wr_byte(dv[i], ack);
            chk("R4 data ack", ack, 1);
        end
        bus_stop();
    endtask

    // Read n bytes after a repeated start; last byte is not acknowledged
    task automatic rd_burst(input int n, input string tag);
        bit ack;
        logic [7:0] got;
        logic [7:0] exp;
        bus_start();
        wr_byte(8'hB5, ack); chk("R1 read address ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            exp_rd(exp);
            rd_byte(got, i != n - 1);
            chk(tag, got, exp);
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) exp_mem[i] = init_val(i);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R10: reset state
        chk("R10 sda released", sda_oe, 0);
        chk("R10 strobe low", reg_we, 0);
        chk("R10 pointer zero", reg_addr, 0);

        begin : main
            bit ack;
            bit b;
            int ones;

            // R1 R3 R4 R5: write burst
            wr_burst(8'h10, 8'hA1, 8'hA2, 8'hA3);
            chk("R4 all writes seen", wq.size(), 0);

            // R7 R9: pointer set, repeated start, read burst
            set_ptr(8'h10);
            rd_burst(3, "R9 R7 read burst data");
            recv_bit(b);
            chk("R8 SDA released after nack", b, 1);
            bus_stop();

            // R2: wrong write address, trailing bytes ignored
            bus_start();
            wr_byte(8'hB6, ack); chk("R2 no ack on wrong address", ack, 0);
            wr_byte(8'h10, ack); chk("R2 ignored byte no ack", ack, 0);
            wr_byte(8'h55, ack); chk("R2 ignored data no ack", ack, 0);
            bus_stop();
            // R2: wrong read address drives nothing
            bus_start();
            wr_byte(8'hB7, ack); chk("R2 no ack on wrong read address", ack, 0);
            ones = 0;
            for (int i = 0; i < 8; i++) begin
                recv_bit(b);
                ones += b;
            end
            chk("R2 no data driven", ones, 8);
            bus_stop();
            // R2 R9: pointer untouched (was 0x13), registers untouched
            rd_burst(1, "R2 pointer and data unchanged");
            bus_stop();
            set_ptr(8'h10);
            rd_burst(1, "R2 register unchanged");
            bus_stop();

            // R11: wrap in write and read
            wr_burst(8'hFE, 8'h11, 8'h22, 8'h33);
            chk("R11 pointer wrapped", reg_addr, 8'h01);
            set_ptr(8'hFE);
            rd_burst(3, "R11 read across wrap");
            bus_stop();

            // R6: stop after four bits of a data byte
            set_ptr(8'h20);
            exp_wr(8'h77);
            wr_byte(8'h77, ack); chk("R4 data ack", ack, 1);
            send_bit(1'b1); send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
            bus_stop();
            chk("R6 partial byte not written", wq.size(), 0);
            set_ptr(8'h20);
            rd_burst(2, "R6 only full byte stored");
            bus_stop();

            // R9: read continues from current pointer (0x22)
            rd_burst(1, "R9 read from kept pointer");
            bus_stop();

            // R12: repeated start inside the address byte
            bus_start();
            send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
            wr_burst(8'h30, 8'h44, 8'h45, 8'h46);
            chk("R12 writes after restart", wq.size(), 0);
            set_ptr(8'h30);
            rd_burst(3, "R12 data after restart");
            bus_stop();

            // R5: strobe count matches bytes
            chk("R5 no leftover writes", wq.size(), 0);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule